// File: doc/BRIEF.md
# In-Flight Load Miss-Level Stall Monitor

This block keeps a table of loads that have been sent to the memory hierarchy and have not yet come back. For each load it records how far down the hierarchy the load has missed so far. Every cycle it combines that table with the number of instructions issued to the functional units, and it keeps five running stall counters. One counter is for execution-stall cycles. The other four are for memory-stall cycles, grouped by the deepest miss level reached by any outstanding load.

A load is added by tag when its send to the cache succeeds. It is removed when its response returns or when it is squashed. A miss-depth update port can raise the recorded level of a live entry. The table is a valid/depth array indexed by tag, and its size is capped by a load-queue capacity parameter. An attempt to insert while the table is at that cap is refused, and a one-cycle error pulse flags it. A zero-issue cycle can be charged to several miss levels at once, because a load that has reached a deep level has also passed every shallower one.

Top module: `load_stall_monitor`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, all five counters read 0, `insert_err` is 0 and the table is empty.
- R2: A `send_valid` with tag T makes entry T valid with recorded depth 0 from the next cycle on, provided fewer than `MAX_INFLIGHT` entries are valid.
- R3: A `send_valid` while `MAX_INFLIGHT` entries are already valid is refused and leaves the table unchanged. `insert_err` is 1 in the cycle after it and 0 otherwise.
- R4: A `resp_valid` with tag T clears entry T from the next cycle on.
- R5: A `squash_valid` with tag T clears entry T. A squash of a tag that is not valid changes nothing.
- R6: A response and a squash for the same tag in one cycle clear that entry once and raise no error.
- R7: `depth_valid` with a level L (0 to 3) sets the depth of a valid entry to L only if L is greater than its current depth. A lower or equal level, or an update to a tag that is not valid, has no effect. If a removal of the same tag arrives in the same cycle, the removal wins. If an insert of the same tag arrives in the same cycle, the insert wins and sets depth 0.
- R8: `exec_stall_cnt` increments by 1 in every cycle in which `issue_count` is below 4.
- R9: `mem_any_cnt` increments by 1 in every cycle in which `issue_count` is 0 and at least one entry is valid.
- R10: In a cycle in which `issue_count` is 0, `mem_l1_cnt`, `mem_l2_cnt` and `mem_l3_cnt` each increment by 1 if some valid entry has a depth of at least 1, 2 or 3 respectively. Several of these counters may step in the same cycle.
- R11: Counters are charged against the table as it stood at the start of a cycle. Sends, removals and depth updates in that cycle first affect the counters one cycle later. All outputs are registered and change one clock after the cycle they describe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| send_valid | input | 1 | A load was sent to the cache successfully |
| send_tag | input | TAG_W | Tag of the sent load |
| resp_valid | input | 1 | A load response arrived |
| resp_tag | input | TAG_W | Tag of the answered load |
| squash_valid | input | 1 | A load was squashed |
| squash_tag | input | TAG_W | Tag of the squashed load |
| depth_valid | input | 1 | Miss-depth update for a tag |
| depth_tag | input | TAG_W | Tag whose depth is updated |
| depth_level | input | 2 | New miss depth, 0 to 3 |
| issue_count | input | ISSUE_W | Instructions issued to functional units this cycle |
| exec_stall_cnt | output | CNT_W | Cycles with fewer than 4 issued |
| mem_any_cnt | output | CNT_W | Zero-issue cycles with any load in flight |
| mem_l1_cnt | output | CNT_W | Zero-issue cycles with a load at depth 1 or more |
| mem_l2_cnt | output | CNT_W | Zero-issue cycles with a load at depth 2 or more |
| mem_l3_cnt | output | CNT_W | Zero-issue cycles with a load at depth 3 |
| insert_err | output | 1 | Pulse: a send was refused because the table was at capacity |

## Verification
Directed patterns walk one load through insert, raise, attempted lowering and removal. Zero-issue probe cycles after each step show whether the entry and its depth are present. This separates insertion, response, squash, absent-tag squash and ignored depth updates. Further directed steps fill the table to capacity to show refusal, fire a response and a squash together, and send in a zero-issue cycle to show the one-cycle lag of R11. Issue counts of 3, 4 and 0 separate the execution-stall threshold from the zero-issue memory condition. A long random mix of all ports against a reference table model exercises the overlapping same-cycle priorities.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int DEPTH_W = 2;
  localparam int NUM_LEVELS = 4;
  typedef logic [DEPTH_W-1:0] depth_t;
endpackage

// File: rtl/lsm_inflight_table.sv
module lsm_inflight_table
  import lsm_pkg::*;
#(
  parameter int NUM_TAGS     = 16,
  parameter int MAX_INFLIGHT = 12,
  localparam int TAG_W       = $clog2(NUM_TAGS),
  localparam int OCC_W       = $clog2(NUM_TAGS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  send_valid,
  input  logic [TAG_W-1:0]      send_tag,
  input  logic                  resp_valid,
  input  logic [TAG_W-1:0]      resp_tag,
  input  logic                  squash_valid,
  input  logic [TAG_W-1:0]      squash_tag,
  input  logic                  depth_valid,
  input  logic [TAG_W-1:0]      depth_tag,
  input  depth_t                depth_level,
  output logic [NUM_LEVELS-1:0] level_any,
  output logic                  ins_reject
);

  logic [NUM_TAGS-1:0] valid_q;
  depth_t              depth_q [NUM_TAGS];
  logic [OCC_W-1:0]    occ;
  logic                ins_accept;
  logic [NUM_TAGS-1:0] ins_vec, rm_vec, upd_vec;

  always_comb begin
    occ = '0;
    for (int i = 0; i < NUM_TAGS; i++) occ = occ + OCC_W'(valid_q[i]);
  end

  assign ins_accept = send_valid && (occ < OCC_W'(MAX_INFLIGHT));
  assign ins_reject = send_valid && !ins_accept;

  always_comb begin
    for (int i = 0; i < NUM_TAGS; i++) begin
      ins_vec[i] = ins_accept && (send_tag == TAG_W'(i));
      rm_vec[i]  = (resp_valid && (resp_tag == TAG_W'(i))) ||
                   (squash_valid && (squash_tag == TAG_W'(i)));
      upd_vec[i] = depth_valid && (depth_tag == TAG_W'(i)) && valid_q[i] &&
                   (depth_level > depth_q[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      for (int i = 0; i < NUM_TAGS; i++) depth_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_TAGS; i++) begin
        if (ins_vec[i]) begin
          valid_q[i] <= 1'b1;
          depth_q[i] <= '0;
        end else if (rm_vec[i]) begin
          valid_q[i] <= 1'b0;
        end else if (upd_vec[i]) begin
          depth_q[i] <= depth_level;
        end
      end
    end
  end

  // Per-level OR reduction of (valid AND depth >= level)
  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_level
    if (l == 0) begin : g_any
      assign level_any[l] = |valid_q;
    end else begin : g_deep
      logic [NUM_TAGS-1:0] hit;
      always_comb begin
        for (int j = 0; j < NUM_TAGS; j++)
          hit[j] = valid_q[j] && (depth_q[j] >= DEPTH_W'(l));
      end
      assign level_any[l] = |hit;
    end
  end

  p_occ_limit_r3: assert property (@(posedge clk) disable iff (rst)
    $countones(valid_q) <= MAX_INFLIGHT);

  p_resp_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !(ins_accept && send_tag == resp_tag)) |=> !valid_q[$past(resp_tag)]);

  p_squash_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (squash_valid && !(ins_accept && send_tag == squash_tag)) |=> !valid_q[$past(squash_tag)]);

  for (genvar i = 0; i < NUM_TAGS; i++) begin : g_chk
    p_depth_nodrop_r7: assert property (@(posedge clk) disable iff (rst)
      (valid_q[i] && !ins_vec[i]) |=> (depth_q[i] >= $past(depth_q[i])));
    p_insert_zero_r2: assert property (@(posedge clk) disable iff (rst)
      ins_vec[i] |=> (valid_q[i] && depth_q[i] == '0));
  end

endmodule

// File: rtl/lsm_stall_counters.sv
module lsm_stall_counters
  import lsm_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int ISSUE_W    = 3,
  parameter int EXEC_LIMIT = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [ISSUE_W-1:0]              issue_count,
  input  logic [NUM_LEVELS-1:0]           level_any,
  output logic [CNT_W-1:0]                exec_cnt,
  output logic [NUM_LEVELS-1:0][CNT_W-1:0] lvl_cnt
);

  logic zero_issue;
  assign zero_issue = (issue_count == '0);

  always_ff @(posedge clk) begin
    if (rst) exec_cnt <= '0;
    else if (issue_count < ISSUE_W'(EXEC_LIMIT)) exec_cnt <= exec_cnt + CNT_W'(1);
  end

  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) lvl_cnt[l] <= '0;
      else if (zero_issue && level_any[l]) lvl_cnt[l] <= lvl_cnt[l] + CNT_W'(1);
    end
    if (l > 0) begin : g_nest
      p_level_nest_r10: assert property (@(posedge clk) disable iff (rst)
        (lvl_cnt[l] != $past(lvl_cnt[l])) |-> (lvl_cnt[l-1] != $past(lvl_cnt[l-1])));
    end
    p_level_needs_idle_r9: assert property (@(posedge clk) disable iff (rst)
      (issue_count != '0) |=> (lvl_cnt[l] == $past(lvl_cnt[l])));
  end

  p_exec_step_r8: assert property (@(posedge clk) disable iff (rst)
    (issue_count >= ISSUE_W'(EXEC_LIMIT)) |=> $stable(exec_cnt));

endmodule

// File: rtl/load_stall_monitor.sv
module load_stall_monitor
  import lsm_pkg::*;
#(
  parameter int NUM_TAGS     = 16,
  parameter int MAX_INFLIGHT = 12,
  parameter int ISSUE_W      = 3,
  parameter int EXEC_LIMIT   = 4,
  parameter int CNT_W        = 32,
  localparam int TAG_W       = $clog2(NUM_TAGS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               send_valid,
  input  logic [TAG_W-1:0]   send_tag,
  input  logic               resp_valid,
  input  logic [TAG_W-1:0]   resp_tag,
  input  logic               squash_valid,
  input  logic [TAG_W-1:0]   squash_tag,
  input  logic               depth_valid,
  input  logic [TAG_W-1:0]   depth_tag,
  input  logic [1:0]         depth_level,
  input  logic [ISSUE_W-1:0] issue_count,
  output logic [CNT_W-1:0]   exec_stall_cnt,
  output logic [CNT_W-1:0]   mem_any_cnt,
  output logic [CNT_W-1:0]   mem_l1_cnt,
  output logic [CNT_W-1:0]   mem_l2_cnt,
  output logic [CNT_W-1:0]   mem_l3_cnt,
  output logic               insert_err
);

  logic [NUM_LEVELS-1:0]            level_any;
  logic                             ins_reject;
  logic [NUM_LEVELS-1:0][CNT_W-1:0] lvl_cnt;

  lsm_inflight_table #(
    .NUM_TAGS    (NUM_TAGS),
    .MAX_INFLIGHT(MAX_INFLIGHT)
  ) u_table (
    .clk         (clk),
    .rst         (rst),
    .send_valid  (send_valid),
    .send_tag    (send_tag),
    .resp_valid  (resp_valid),
    .resp_tag    (resp_tag),
    .squash_valid(squash_valid),
    .squash_tag  (squash_tag),
    .depth_valid (depth_valid),
    .depth_tag   (depth_tag),
    .depth_level (depth_level),
    .level_any   (level_any),
    .ins_reject  (ins_reject)
  );

  lsm_stall_counters #(
    .CNT_W     (CNT_W),
    .ISSUE_W   (ISSUE_W),
    .EXEC_LIMIT(EXEC_LIMIT)
  ) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .issue_count(issue_count),
    .level_any  (level_any),
    .exec_cnt   (exec_stall_cnt),
    .lvl_cnt    (lvl_cnt)
  );

  assign mem_any_cnt = lvl_cnt[0];
  assign mem_l1_cnt  = lvl_cnt[1];
  assign mem_l2_cnt  = lvl_cnt[2];
  assign mem_l3_cnt  = lvl_cnt[3];

  always_ff @(posedge clk) begin
    if (rst) insert_err <= 1'b0;
    else     insert_err <= ins_reject;
  end

  p_err_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    insert_err |-> $past(send_valid));

  p_err_clear_r6: assert property (@(posedge clk) disable iff (rst)
    !send_valid |=> !insert_err);

endmodule

// File: tb/load_stall_monitor_test.sv
module load_stall_monitor_test;
  localparam int NT = 16;
  localparam int MAXF = 12;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic send_valid = 0, resp_valid = 0, squash_valid = 0, depth_valid = 0;
  logic [TW-1:0] send_tag = 0, resp_tag = 0, squash_tag = 0, depth_tag = 0;
  logic [1:0] depth_level = 0;
  logic [2:0] issue_count = 3'd4;
  logic [31:0] exec_stall_cnt, mem_any_cnt, mem_l1_cnt, mem_l2_cnt, mem_l3_cnt;
  logic insert_err;

  always #2.5 clk = ~clk;

  load_stall_monitor uut (
    .clk(clk), .rst(rst),
    .send_valid(send_valid), .send_tag(send_tag),
    .resp_valid(resp_valid), .resp_tag(resp_tag),
    .squash_valid(squash_valid), .squash_tag(squash_tag),
    .depth_valid(depth_valid), .depth_tag(depth_tag), .depth_level(depth_level),
    .issue_count(issue_count),
    .exec_stall_cnt(exec_stall_cnt), .mem_any_cnt(mem_any_cnt),
    .mem_l1_cnt(mem_l1_cnt), .mem_l2_cnt(mem_l2_cnt), .mem_l3_cnt(mem_l3_cnt),
    .insert_err(insert_err)
  );

  int checks = 0, fails = 0;
  bit m_valid [NT];
  int m_depth [NT];
  int e_exec = 0;
  int e_lvl [4] = '{0, 0, 0, 0};
  int q_exec[$], q_any[$], q_l1[$], q_l2[$], q_l3[$], q_err[$];
  string q_lbl[$];
  bit monitor_on = 0;

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: drive one cycle at the falling edge and push its expected outcome
  task automatic step(bit sv, int st, bit rv, int rt, bit qv, int qt,
                      bit dv, int dt, int dl, int iss, string lbl);
    int occ;
    bit acc, err;
    bit hit [4];
    @(negedge clk);
    send_valid = sv; send_tag = TW'(st);
    resp_valid = rv; resp_tag = TW'(rt);
    squash_valid = qv; squash_tag = TW'(qt);
    depth_valid = dv; depth_tag = TW'(dt); depth_level = 2'(dl);
    issue_count = 3'(iss);
    occ = 0;
    for (int t = 0; t < NT; t++) occ += m_valid[t];
    for (int l = 0; l < 4; l++) begin
      hit[l] = 0;
      for (int t = 0; t < NT; t++) if (m_valid[t] && m_depth[t] >= l) hit[l] = 1;
    end
    if (iss < 4) e_exec++;
    if (iss == 0) for (int l = 0; l < 4; l++) if (hit[l]) e_lvl[l]++;
    acc = sv && (occ < MAXF);
    err = sv && !acc;
    for (int t = 0; t < NT; t++) begin
      if (acc && st == t) begin m_valid[t] = 1; m_depth[t] = 0; end
      else if ((rv && rt == t) || (qv && qt == t)) m_valid[t] = 0;
      else if (dv && dt == t && m_valid[t] && dl > m_depth[t]) m_depth[t] = dl;
    end
    q_exec.push_back(e_exec); q_any.push_back(e_lvl[0]);
    q_l1.push_back(e_lvl[1]); q_l2.push_back(e_lvl[2]); q_l3.push_back(e_lvl[3]);
    q_err.push_back(int'(err)); q_lbl.push_back(lbl);
  endtask

  task automatic idle(int iss, string lbl);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, iss, lbl);
  endtask

  // Monitor: after each rising edge, pop and compare
  initial begin
    forever begin
      @(posedge clk); #1;
      if (monitor_on && q_exec.size() > 0) begin
        string lbl;
        lbl = q_lbl.pop_front();
        check({lbl, " R8"}, "exec_stall_cnt", exec_stall_cnt, q_exec.pop_front());
        check({lbl, " R9"}, "mem_any_cnt", mem_any_cnt, q_any.pop_front());
        check({lbl, " R10"}, "mem_l1_cnt", mem_l1_cnt, q_l1.pop_front());
        check({lbl, " R10"}, "mem_l2_cnt", mem_l2_cnt, q_l2.pop_front());
        check({lbl, " R10"}, "mem_l3_cnt", mem_l3_cnt, q_l3.pop_front());
        check({lbl, " R3"}, "insert_err", insert_err, q_err.pop_front());
      end
    end
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int t = 0; t < NT; t++) begin m_valid[t] = 0; m_depth[t] = 0; end
    repeat (4) @(negedge clk);
    check("R1", "exec_stall_cnt in reset", exec_stall_cnt, 0);
    check("R1", "insert_err in reset", insert_err, 0);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R1", "mem_any_cnt after reset", mem_any_cnt, 0);
    check("R1", "mem_l3_cnt after reset", mem_l3_cnt, 0);
    monitor_on = 1;

    idle(0, "R1 empty");
    // R2 insert
    step(1, 3, 0, 0, 0, 0, 0, 0, 0, 4, "R2 send");
    idle(0, "R2 probe");
    // R7 raise, lower ignored, absent ignored
    step(0, 0, 0, 0, 0, 0, 1, 3, 2, 4, "R7 raise");
    idle(0, "R7 raised");
    step(0, 0, 0, 0, 0, 0, 1, 3, 1, 4, "R7 lower");
    idle(0, "R7 unchanged");
    step(0, 0, 0, 0, 0, 0, 1, 9, 3, 4, "R7 absent");
    idle(0, "R7 absent probe");
    // R5 squash of absent tag
    step(0, 0, 0, 0, 1, 5, 0, 0, 0, 4, "R5 absent squash");
    idle(0, "R5 probe");
    // R4 response
    step(0, 0, 1, 3, 0, 0, 0, 0, 0, 4, "R4 resp");
    idle(0, "R4 probe");
    // R5 squash of live entry at depth 3
    step(1, 7, 0, 0, 0, 0, 0, 0, 0, 4, "R5 send");
    step(0, 0, 0, 0, 0, 0, 1, 7, 3, 4, "R10 deep");
    idle(0, "R10 all levels");
    step(0, 0, 0, 0, 1, 7, 0, 0, 0, 4, "R5 squash");
    idle(0, "R5 cleared");
    // R6 response and squash together
    step(1, 4, 0, 0, 0, 0, 0, 0, 0, 4, "R6 send");
    step(0, 0, 1, 4, 1, 4, 1, 4, 3, 4, "R6 both");
    idle(0, "R6 probe");
    // R11 send during zero-issue cycle is not yet counted
    step(1, 6, 0, 0, 0, 0, 0, 0, 0, 0, "R11 send idle");
    step(0, 0, 1, 6, 0, 0, 0, 0, 0, 0, "R11 resp idle");
    idle(0, "R11 gone");
    // R8 threshold
    idle(3, "R8 three");
    idle(4, "R8 four");
    idle(7, "R8 seven");
    // R3 capacity
    for (int t = 0; t < MAXF; t++) step(1, t, 0, 0, 0, 0, 0, 0, 0, 4, "R3 fill");
    step(1, 15, 0, 0, 0, 0, 0, 0, 0, 4, "R3 refused");
    idle(4, "R3 err drops");
    for (int t = 0; t < MAXF; t++) step(0, 0, 1, t, 0, 0, 0, 0, 0, 4, "R3 drain");
    idle(0, "R3 refused tag absent");
    // Random mix
    for (int n = 0; n < 400; n++)
      step($urandom_range(0, 1), $urandom_range(0, NT - 1),
           $urandom_range(0, 3) == 0, $urandom_range(0, NT - 1),
           $urandom_range(0, 5) == 0, $urandom_range(0, NT - 1),
           $urandom_range(0, 1), $urandom_range(0, NT - 1), $urandom_range(0, 3),
           $urandom_range(0, 5), "R7 R11 random");
    idle(4, "tail");
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule